// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer with Early Row Close

This block runs the command sequence for one SDRAM read burst. It opens the row, issues the read, and then closes the row with a precharge. The precharge is placed by the last data element the requester actually wants, not by the end of the burst. This lets the block cut a burst short, or stand in for auto precharge on a full burst of four, while part of the row-precharge time overlaps the final data beats.

A request carries:
- a bank and a row;
- a column;
- a burst-length code;
- the zero-based index of the last wanted element;
- a flag that turns the closing precharge into an all-bank precharge.

Requests are taken with a valid/ready handshake. The CAS latency (2 or 3) and the row-precharge time tRP (in cycles) are run-time inputs. The block counts tRP per bank. It holds ready low for a bank that is still precharging, so the next ACTIVE to that bank comes no earlier than tRP cycles after its precharge. A flag marks each delivered data beat at the cycle it is valid on the pins.

Commands are driven on `cmd_o` with the following encoding:

| Code | Command |
|------|---------|
| 0 | NOP |
| 1 | ACTIVE |
| 2 | READ |
| 3 | PRECHARGE |

Address bit `AP_BIT` (default 10) is the all-bank flag on PRECHARGE. It is the auto-precharge bit on READ and is always 0 there. The column is carried in the low `COL_W` bits of READ. The row is carried on the full address of ACTIVE. `ACT_TO_RD` must be at least 2.

Top module: `sdram_rd_preclose`

## Requirements
- R1: After reset, `cmd_o` is NOP (0), `rd_valid_o` is 0, and `req_ready_o` is 1.
- R2: A request accepted at a clock edge produces ACTIVE (code 1) in the next cycle, with the request bank and the row on the address. READ (code 2) follows `ACT_TO_RD` (default 2) cycles after ACTIVE, with the column in the low `COL_W` bits and address bit `AP_BIT` equal to 0.
- R3: Let L be the effective last index. PRECHARGE (code 3) comes exactly L+1 cycles after READ, which is (CAS latency − 1) cycles before the cycle in which element L is valid. It is never earlier than the cycle after READ. It carries the request bank, and address bit `AP_BIT` equal to the all-bank flag.
- R4: `rd_valid_o` is high for exactly L+1 consecutive cycles, starting CAS-latency cycles after READ. `cas_lat_i` value 3 selects latency 3 and every other value selects latency 2. The latency is sampled in the cycle READ is issued.
- R5: The burst-length code `req_len_i` maps to a burst length as follows:
  - codes 0, 1, 2 and 3 give 1, 2, 4 and 8 elements;
  - codes 4 to 7 give a full page of 2^`COL_W` elements.

  The effective last index is the smaller of `req_last_i` and the burst length minus 1.
- R6: Every cycle between ACTIVE and READ, and between READ and PRECHARGE, carries NOP, so exactly three non-NOP commands make up one sequence.
- R7: After a single-bank PRECHARGE to bank b, a waiting request to bank b gets its ACTIVE exactly tRP cycles after the PRECHARGE, for tRP ≥ 1. No ACTIVE to bank b ever comes earlier.
- R8: An all-bank PRECHARGE blocks every bank for tRP cycles in the same way.
- R9: A request to a bank other than the one just precharged is accepted in the PRECHARGE cycle, and its ACTIVE follows in the next cycle.
- R10: `req_ready_o` is low from the ACTIVE cycle through the cycle before PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat_i | input | 2 | CAS latency select (3 = three cycles, else two) |
| trp_cycles_i | input | TRP_W | Row-precharge time in cycles, at least 1 |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready for the bank on `req_bank_i` |
| req_bank_i | input | BANK_W | Request bank |
| req_row_i | input | ROW_W | Row to open |
| req_col_i | input | COL_W | Start column |
| req_len_i | input | 3 | Burst-length code |
| req_last_i | input | COL_W | Index of last wanted element |
| req_close_all_i | input | 1 | Close with all-bank precharge |
| cmd_o | output | 2 | Command code |
| cmd_bank_o | output | BANK_W | Command bank |
| cmd_addr_o | output | ROW_W | Command address |
| rd_valid_o | output | 1 | Read data beat valid on the pins |

## Verification
The bench covers the following corner cases, each with the failure it would expose:
- **Latency independence of the precharge.** The precharge position must not depend on CAS latency. A design that adds the latency into the precharge offset would close the row one cycle late at latency 3.
- **Last index 0.** The precharge must land right after READ. A design that is off by one would collide with READ or slip a cycle.
- **Clamping.** Each burst-length code, including full page, is tested with a last index beyond the burst. A design that ignores the clamp delivers extra beats and precharges late.
- **Back-to-back requests.** These are tested with tRP of 1, 3 and 4, with an all-bank close, and with a different bank. They catch an off-by-one in the precharge counter, a lock on the wrong bank, or a needless stall for an unrelated bank.

// File: rtl/sdrp_pkg.sv
package sdrp_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_PRE = 2'd3
    } sdrp_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_READ = 2'd2
    } sdrp_state_e;

endpackage

// File: rtl/sdrp_len_decode.sv
// Clamps the wanted last index to the end of the selected burst.
module sdrp_len_decode #(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_code_i,
    input  logic [COL_W-1:0] last_i,
    output logic [COL_W-1:0] last_o
);
    logic [COL_W-1:0] span;

    always_comb begin
        span = '1;
        if (!len_code_i[2]) begin
            span = COL_W'((4'd1 << len_code_i[1:0]) - 4'd1);
        end
        last_o = (last_i > span) ? span : last_i;
    end
endmodule

// File: rtl/sdrp_bank_timer.sv
// One precharge-time down-counter per bank; a bank is free at zero.
module sdrp_bank_timer #(
    parameter int NUM_BANKS = 4,
    parameter int TRP_W     = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 load_all_i,
    input  logic [BANK_W-1:0]    load_bank_i,
    input  logic [TRP_W-1:0]     trp_i,
    output logic [NUM_BANKS-1:0] free_o
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [TRP_W-1:0] cnt_d, cnt_q;
        logic             hit;

        always_comb begin
            hit   = load_i && (load_all_i || (load_bank_i == BANK_W'(b)));
            cnt_d = cnt_q;
            if (hit) begin
                // counting starts in the precharge cycle itself
                cnt_d = (trp_i == '0) ? '0 : trp_i - 1'b1;
            end else if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign free_o[b] = (cnt_q == '0);
    end
endmodule

// File: rtl/sdrp_beat_track.sv
// Flags each delivered beat CAS-latency cycles after READ.
module sdrp_beat_track #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cl3_i,
    input  logic [COL_W-1:0] last_i,
    output logic             valid_o
);
    typedef struct packed {
        logic [1:0]     dly;
        logic [COL_W:0] rem;
        logic           valid;
    } beat_t;

    beat_t d, q;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (q.dly > 2'd1) begin
            d.dly = q.dly - 2'd1;
        end else if (q.dly == 2'd1) begin
            d.dly   = 2'd0;
            d.valid = 1'b1;
            d.rem   = q.rem - 1'b1;
        end else if (q.rem != '0) begin
            d.valid = 1'b1;
            d.rem   = q.rem - 1'b1;
        end
        if (start_i) begin
            d.dly = cl3_i ? 2'd3 : 2'd2;
            d.rem = (COL_W+1)'({1'b0, last_i}) + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid_o = q.valid;
endmodule

// File: rtl/sdram_rd_preclose.sv
module sdram_rd_preclose
    import sdrp_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 8,
    parameter int AP_BIT    = 10,
    parameter int TRP_W     = 4,
    parameter int ACT_TO_RD = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ADDR_W   = ROW_W,
    localparam int RCD_W    = $clog2(ACT_TO_RD + 1),
    localparam int WAIT_W   = (COL_W > RCD_W) ? COL_W : RCD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cas_lat_i,
    input  logic [TRP_W-1:0]  trp_cycles_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [BANK_W-1:0] req_bank_i,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic [COL_W-1:0]  req_col_i,
    input  logic [2:0]        req_len_i,
    input  logic [COL_W-1:0]  req_last_i,
    input  logic              req_close_all_i,
    output logic [1:0]        cmd_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic              rd_valid_o
);
    typedef struct packed {
        sdrp_state_e       st;
        logic [WAIT_W-1:0] wait_cnt;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [COL_W-1:0]  last;
        logic              all;
        sdrp_cmd_e         cmd;
        logic [BANK_W-1:0] cmd_bank;
        logic [ADDR_W-1:0] cmd_addr;
    } seq_t;

    seq_t d, q;

    logic [COL_W-1:0]     last_eff;
    logic [NUM_BANKS-1:0] bank_free;
    logic                 accept;
    logic                 read_go;
    logic                 pre_go;

    sdrp_len_decode #(.COL_W(COL_W)) i_len (
        .len_code_i (req_len_i),
        .last_i     (req_last_i),
        .last_o     (last_eff)
    );

    assign req_ready_o = (q.st == ST_IDLE) && bank_free[req_bank_i];
    assign accept      = req_valid_i && req_ready_o;
    assign read_go     = (q.st == ST_OPEN) && (q.wait_cnt == '0);
    assign pre_go      = (q.st == ST_READ) && (q.wait_cnt == '0);

    always_comb begin
        d          = q;
        d.cmd      = CMD_NOP;
        d.cmd_bank = '0;
        d.cmd_addr = '0;
        case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.st       = ST_OPEN;
                    d.bank     = req_bank_i;
                    d.col      = req_col_i;
                    d.last     = last_eff;
                    d.all      = req_close_all_i;
                    d.wait_cnt = WAIT_W'(ACT_TO_RD - 1);
                    d.cmd      = CMD_ACT;
                    d.cmd_bank = req_bank_i;
                    d.cmd_addr = req_row_i;
                end
            end
            ST_OPEN: begin
                if (read_go) begin
                    // precharge lands last+1 cycles after READ for any latency
                    d.st       = ST_READ;
                    d.wait_cnt = WAIT_W'(q.last);
                    d.cmd      = CMD_RD;
                    d.cmd_bank = q.bank;
                    d.cmd_addr = ADDR_W'(q.col);
                end else begin
                    d.wait_cnt = q.wait_cnt - 1'b1;
                end
            end
            ST_READ: begin
                if (pre_go) begin
                    d.st               = ST_IDLE;
                    d.cmd              = CMD_PRE;
                    d.cmd_bank         = q.bank;
                    d.cmd_addr[AP_BIT] = q.all;
                end else begin
                    d.wait_cnt = q.wait_cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    sdrp_bank_timer #(.NUM_BANKS(NUM_BANKS), .TRP_W(TRP_W)) i_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (pre_go),
        .load_all_i  (q.all),
        .load_bank_i (q.bank),
        .trp_i       (trp_cycles_i),
        .free_o      (bank_free)
    );

    sdrp_beat_track #(.COL_W(COL_W)) i_beats (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (read_go),
        .cl3_i   (cas_lat_i == 2'd3),
        .last_i  (q.last),
        .valid_o (rd_valid_o)
    );

    assign cmd_o      = q.cmd;
    assign cmd_bank_o = q.cmd_bank;
    assign cmd_addr_o = q.cmd_addr;
endmodule

// File: rtl/sdrp_checker.sv
module sdrp_checker
    import sdrp_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10,
    parameter int TRP_W     = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cmd_o,
    input logic [BANK_W-1:0] cmd_bank_o,
    input logic [ADDR_W-1:0] cmd_addr_o,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic [TRP_W-1:0]  trp_cycles_i
);
    // cycles since each bank's last precharge, saturating
    logic [NUM_BANKS-1:0][TRP_W:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '1;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (cmd_o == CMD_PRE &&
                    (cmd_addr_o[AP_BIT] || cmd_bank_o == BANK_W'(b))) begin
                    since_q[b] <= (TRP_W+1)'(1);
                end else if (since_q[b] != '1) begin
                    since_q[b] <= since_q[b] + 1'b1;
                end
            end
        end
    end

    p_act_bank_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT) |-> (since_q[cmd_bank_o] >= {1'b0, trp_cycles_i}));

    p_read_no_autopre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_RD) |-> !cmd_addr_o[AP_BIT]);

    p_accept_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> (cmd_o == CMD_ACT));

    p_read_then_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_RD) |=> (cmd_o == CMD_NOP || cmd_o == CMD_PRE));

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT) |-> !req_ready_o);
endmodule

bind sdram_rd_preclose sdrp_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ROW_W),
    .AP_BIT    (AP_BIT),
    .TRP_W     (TRP_W)
) i_sdrp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_o        (cmd_o),
    .cmd_bank_o   (cmd_bank_o),
    .cmd_addr_o   (cmd_addr_o),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .trp_cycles_i (trp_cycles_i)
);

// File: tb/test_sdram_rd_preclose.sv
module test_sdram_rd_preclose;
    localparam int CLK_PERIOD = 10;
    localparam int RCD        = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cas_lat_i = 2'd2;
    logic [3:0]  trp_cycles_i = 4'd2;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [1:0]  req_bank_i = '0;
    logic [12:0] req_row_i = '0;
    logic [7:0]  req_col_i = '0;
    logic [2:0]  req_len_i = '0;
    logic [7:0]  req_last_i = '0;
    logic        req_close_all_i = 1'b0;
    logic [1:0]  cmd_o;
    logic [1:0]  cmd_bank_o;
    logic [12:0] cmd_addr_o;
    logic        rd_valid_o;

    sdram_rd_preclose i_sdram_rd_preclose (
        .clk(clk), .rst_n(rst_n), .cas_lat_i(cas_lat_i), .trp_cycles_i(trp_cycles_i),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_bank_i(req_bank_i),
        .req_row_i(req_row_i), .req_col_i(req_col_i), .req_len_i(req_len_i),
        .req_last_i(req_last_i), .req_close_all_i(req_close_all_i), .cmd_o(cmd_o),
        .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o), .rd_valid_o(rd_valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0;
    int act_cyc = -1, act_bank, act_addr;
    int rd_cyc = -1, rd_addr;
    int pre_cyc = -1, pre_bank, pre_addr;
    int ncmd = 0, nbeats = 0, first_beat = -1, last_beat = -1, busy_err = 0;
    bit busy = 0;

    // observer, samples on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            case (cmd_o)
                2'd1: begin act_cyc = cyc; act_bank = int'(cmd_bank_o);
                            act_addr = int'(cmd_addr_o); ncmd = 1; busy = 1; end
                2'd2: begin rd_cyc = cyc; rd_addr = int'(cmd_addr_o);
                            ncmd++; nbeats = 0; end
                2'd3: begin pre_cyc = cyc; pre_bank = int'(cmd_bank_o);
                            pre_addr = int'(cmd_addr_o); ncmd++; busy = 0; end
                default: ;
            endcase
            if (busy && req_ready_o) busy_err++;
            if (rd_valid_o) begin
                if (nbeats == 0) first_beat = cyc;
                last_beat = cyc;
                nbeats++;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    // present a request and wait for it to be taken; returns acceptance cycle
    task automatic start_req(int bank, int row, int col, int code, int last,
                             bit all, output int acc);
        @(negedge clk); #1;
        req_bank_i = 2'(bank); req_row_i = 13'(row); req_col_i = 8'(col);
        req_len_i = 3'(code); req_last_i = 8'(last); req_close_all_i = all;
        req_valid_i = 1'b1;
        #1;
        while (!req_ready_o) begin
            @(negedge clk); #2;
        end
        acc = cyc;
        @(posedge clk); #1;
        req_valid_i = 1'b0;
    endtask

    task automatic check_seq(string name, int acc, int bank, int row, int col,
                             bit all, int el, int cl);
        int exp_rd;
        while (pre_cyc <= acc) begin
            @(negedge clk); #1;
        end
        repeat (5) @(negedge clk);
        #1;
        exp_rd = acc + 1 + RCD;
        chk({name, " R2 act cycle"}, act_cyc, acc + 1);
        chk({name, " R2 act bank"}, act_bank, bank);
        chk({name, " R2 act row"}, act_addr, row);
        chk({name, " R2 read cycle"}, rd_cyc, exp_rd);
        chk({name, " R2 read col"}, rd_addr & 8'hFF, col);
        chk({name, " R2 read ap bit"}, (rd_addr >> 10) & 1, 0);
        chk({name, " R3 pre cycle"}, pre_cyc, exp_rd + el + 1);
        chk({name, " R3 pre bank"}, pre_bank, bank);
        chk({name, " R3 pre all flag"}, (pre_addr >> 10) & 1, int'(all));
        chk({name, " R3 pre to last beat"}, last_beat - pre_cyc, cl - 1);
        chk({name, " R4 beat count"}, nbeats, el + 1);
        chk({name, " R4 first beat"}, first_beat, exp_rd + cl);
        chk({name, " R6 command count"}, ncmd, 3);
        chk({name, " R10 ready while busy"}, busy_err, 0);
    endtask

    task automatic run_one(string name, int bank, int row, int col, int code,
                           int last, bit all, int cl_code, int el, int cl);
        int acc;
        cas_lat_i = 2'(cl_code);
        start_req(bank, row, col, code, last, all, acc);
        check_seq(name, acc, bank, row, col, all, el, cl);
    endtask

    task automatic test_reset();
        @(negedge clk); #1;
        chk("R1 cmd after reset", int'(cmd_o), 0);
        chk("R1 rd_valid after reset", int'(rd_valid_o), 0);
        chk("R1 ready after reset", int'(req_ready_o), 1);
    endtask

    // second request waits behind the first; checks ACTIVE spacing
    task automatic test_pair(string name, int trp, int b1, bit all1, int b2, int exp_gap);
        int acc1, acc2, pre1;
        trp_cycles_i = 4'(trp);
        cas_lat_i = 2'd3;
        start_req(b1, 100, 4, 2, 3, all1, acc1);
        start_req(b2, 200, 8, 2, 1, 1'b0, acc2);
        pre1 = pre_cyc;
        chk({name, " gap PRE to ACTIVE"}, acc2 + 1 - pre1, exp_gap);
        check_seq({name, " second"}, acc2, b2, 200, 8, 1'b0, 1, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_one("R3 burst4 full cl2", 1, 77, 16, 2, 3, 1'b0, 2, 3, 2);
        run_one("R3 burst4 full cl3", 2, 78, 32, 2, 3, 1'b0, 3, 3, 3);
        run_one("R3 last0 cl3", 0, 5, 9, 3, 0, 1'b0, 3, 0, 3);
        run_one("R5 len1 clamp", 3, 6, 1, 0, 5, 1'b0, 2, 0, 2);
        run_one("R5 len2 clamp", 1, 7, 2, 1, 7, 1'b0, 3, 1, 3);
        run_one("R5 len8 clamp", 2, 8, 40, 3, 9, 1'b0, 2, 7, 2);
        run_one("R5 full page trunc", 0, 9, 100, 7, 20, 1'b0, 3, 20, 3);
        run_one("R4 cl code0 all", 3, 10, 3, 2, 2, 1'b1, 0, 2, 2);
        test_pair("R7 same bank trp3", 3, 2, 1'b0, 2, 3);
        test_pair("R7 same bank trp1", 1, 1, 1'b0, 1, 1);
        test_pair("R9 other bank", 5, 1, 1'b0, 3, 1);
        test_pair("R8 all banks", 4, 0, 1'b1, 3, 4);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        summary();
        $finish;
    end
endmodule